// File: doc/BRIEF.md
# SDRAM Command Protocol Checker

This block is a passive monitor for a single-rank SDRAM command bus. On every rising clock edge it samples chip select, the three command strobes, clock enable, the two bank-select bits, the address bit that carries the auto-precharge and all-banks flag, and the byte-mask lines. It decodes each command and keeps a small model of each of the four banks: whether a row is open, whether an auto-precharge burst has locked the bank, and how many cycles have passed since that bank's last activate and last precharge. Any command that breaks a timing or state rule produces a one-cycle report made of a valid pulse, a 4-bit code and the bank involved.

The monitor also predicts byte masking. A mask line applies to write data in the cycle it is sampled, but on reads it forces the output to high impedance two cycles later. Two registered mask outputs report both views, so a scoreboard that compares data can ignore the bytes involved. The monitor drives nothing onto the bus. Its timing limits are clock counts set by parameters, and one report is produced per cycle at most. When several rules fail at once, the lowest code wins.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Commands are decoded from {csN,rasN,casN,weN}: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 mode set, 0110 burst stop. 0111 is a no-op, and any cycle with csN high is a deselect whatever the other pins are. No-ops and deselects never raise an error.
- R2: If cke was low at the previous edge, a command (anything but a no-op or deselect) is reported with code 1 and changes no bank state.
- R3: The bank index is {ba[0],ba[1]}: ba[0]=0,ba[1]=0 is bank 0, ba[0]=0,ba[1]=1 is bank 1, ba[0]=1,ba[1]=0 is bank 2, both high is bank 3. This index appears on errBank for bank-specific errors.
- R4: A mode set with any row open gives code 3, and a refresh with any row open gives code 4. errBank is then the lowest open bank.
- R5: Any command fewer than MRS_GAP edges after a mode set gives code 2.
- R6: A read or write to a bank with no open row gives code 6. An activate to a bank with an open row gives code 8.
- R7: A read or write with apBit high locks its bank for the next BURST_LEN-1 edges. A read or write to a locked bank gives code 5. The row closes at the last data edge of the burst, and an activate sooner than T_RP edges after that edge gives code 10.
- R8: A read or write fewer than T_RCD edges after its bank's activate gives code 7. An activate fewer than T_RRD edges after any activate gives code 9.
- R9: An activate fewer than T_RP edges after its bank was precharged gives code 10. An activate fewer than T_RC edges after the same bank's previous activate gives code 11. Precharging an open row fewer than T_RAS edges after its activate gives code 12.
- R10: Reports are registered: a command sampled at edge n produces errValid high for the cycle after edge n only. When several rules fail at once, the lowest code is reported. After reset errValid, wrMask and readHiZ are low.
- R11: wrMask shows, for the cycle after edge n, the dqm value sampled at edge n.
- R12: readHiZ shows, for the cycle after edge n, the dqm value sampled at edge n-2. These are the read bytes forced to high impedance at edge n.
- R13: A precharge with apBit high closes every bank and checks T_RAS on each open row. errBank is the lowest bank that fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples all inputs |
| rstN | input | 1 | Active-low synchronous reset of the monitor |
| csN | input | 1 | Chip select, low active |
| rasN | input | 1 | Row strobe, low active |
| casN | input | 1 | Column strobe, low active |
| weN | input | 1 | Write enable, low active |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank select, ba[0] and ba[1] as in R3 |
| apBit | input | 1 | Address bit for auto-precharge and precharge-all |
| dqm | input | DQM_W | Byte mask lines |
| errValid | output | 1 | One-cycle error report |
| errCode | output | 4 | Error code of the report |
| errBank | output | 2 | Bank involved in the report |
| wrMask | output | DQM_W | Write bytes masked at the previous edge |
| readHiZ | output | DQM_W | Read bytes at high impedance at the previous edge |

## Verification
Two error rules often fail in the same cycle: a command issued while the clock is frozen, one cycle after a mode set, breaks both the freeze rule and the mode-set gap. The bench provokes this and expects the freeze code, since the lower code wins. The byte-mask prediction and an error report can also fall in the same cycle. The bench issues a read to a closed bank while the mask lines are all high, and expects code 6 together with the mask outputs, with read masking lagging by two edges. A table of commands walks through every timing rule at exactly its failing count, and then runs a count later to confirm that the rule is released.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = 2;
  localparam int CODE_W    = 4;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_ACT, CMD_READ, CMD_WRITE, CMD_PRE, CMD_REF, CMD_MRS, CMD_OTHER
  } cmd_e;

  typedef enum logic [CODE_W-1:0] {
    ERR_NONE       = 4'd0,
    ERR_FROZEN     = 4'd1,
    ERR_MRS_GAP    = 4'd2,
    ERR_MRS_BUSY   = 4'd3,
    ERR_REF_BUSY   = 4'd4,
    ERR_LOCKED     = 4'd5,
    ERR_INACTIVE   = 4'd6,
    ERR_RCD        = 4'd7,
    ERR_DOUBLE_ACT = 4'd8,
    ERR_RRD        = 4'd9,
    ERR_RP         = 4'd10,
    ERR_RC         = 4'd11,
    ERR_RAS        = 4'd12
  } err_e;

  // Strobes from the rule logic to the bank tracker, already gated by clock enable.
  typedef struct packed {
    logic              act;
    logic              rdwr;
    logic              autoPre;
    logic              pre;
    logic              preAll;
    logic              mrs;
    logic [BANK_W-1:0] bank;
  } strobe_t;

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdram_mon_track.sv
module sdram_mon_track import sdram_mon_pkg::*; #(
  parameter int T_RCD     = 2,
  parameter int T_RRD     = 2,
  parameter int T_RP      = 2,
  parameter int T_RAS     = 5,
  parameter int T_RC      = 7,
  parameter int MRS_GAP   = 2,
  parameter int BURST_LEN = 4,
  parameter int DQM_W     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic                 cke,
  input  logic [DQM_W-1:0]     dqm,
  output logic                 ckePrev,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic [NUM_BANKS-1:0] bankLocked,
  output logic [NUM_BANKS-1:0] rcdShort,
  output logic [NUM_BANKS-1:0] rasShort,
  output logic [NUM_BANKS-1:0] rcShort,
  output logic [NUM_BANKS-1:0] rpShort,
  output logic                 rrdShort,
  output logic                 mrsShort,
  output logic [DQM_W-1:0]     wrMask,
  output logic [DQM_W-1:0]     readHiZ
);
  localparam int MAX_T = maxInt(maxInt(maxInt(T_RCD, T_RRD), maxInt(T_RP, T_RAS)),
                                maxInt(T_RC, MRS_GAP));
  localparam int AGE_W  = $clog2(MAX_T + 1);
  localparam int LOCK_W = $clog2(BURST_LEN) + 1;
  localparam logic [AGE_W-1:0]  AGE_MAX   = '1;
  localparam logic [AGE_W-1:0]  AGE_ONE   = AGE_W'(1);
  localparam logic [AGE_W-1:0]  LIM_RCD   = AGE_W'(T_RCD);
  localparam logic [AGE_W-1:0]  LIM_RRD   = AGE_W'(T_RRD);
  localparam logic [AGE_W-1:0]  LIM_RP    = AGE_W'(T_RP);
  localparam logic [AGE_W-1:0]  LIM_RAS   = AGE_W'(T_RAS);
  localparam logic [AGE_W-1:0]  LIM_RC    = AGE_W'(T_RC);
  localparam logic [AGE_W-1:0]  LIM_GAP   = AGE_W'(MRS_GAP);
  localparam logic [LOCK_W-1:0] LOCK_LOAD = LOCK_W'(BURST_LEN - 1);
  localparam logic [LOCK_W-1:0] LOCK_LAST = LOCK_W'(1);
  localparam bit                SINGLE    = (BURST_LEN == 1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [AGE_W-1:0]  actAge, preAge;
    logic [LOCK_W-1:0] lockCnt;
    logic              isOpen, hit, actNow, preNow, apNow, closeNow;

    always_comb begin
      hit      = (strb.bank == BANK_W'(b));
      actNow   = strb.act && hit;
      preNow   = strb.pre && (strb.preAll || hit) && isOpen;
      apNow    = strb.rdwr && strb.autoPre && hit && isOpen && (lockCnt == '0);
      closeNow = preNow || (lockCnt == LOCK_LAST) || (apNow && SINGLE);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        isOpen  <= 1'b0;
        lockCnt <= '0;
        actAge  <= AGE_MAX;
        preAge  <= AGE_MAX;
      end else begin
        actAge <= actNow ? AGE_ONE : ((actAge == AGE_MAX) ? actAge : actAge + 1'b1);
        preAge <= (closeNow && !actNow) ? AGE_ONE
                                        : ((preAge == AGE_MAX) ? preAge : preAge + 1'b1);
        if (actNow)        isOpen <= 1'b1;
        else if (closeNow) isOpen <= 1'b0;
        if (preNow)              lockCnt <= '0;
        else if (apNow)          lockCnt <= LOCK_LOAD;
        else if (lockCnt != '0)  lockCnt <= lockCnt - 1'b1;
      end
    end

    assign bankOpen[b]   = isOpen;
    assign bankLocked[b] = (lockCnt != '0);
    assign rcdShort[b]   = (actAge < LIM_RCD);
    assign rasShort[b]   = (actAge < LIM_RAS);
    assign rcShort[b]    = (actAge < LIM_RC);
    assign rpShort[b]    = (preAge < LIM_RP);

    // R7: the last data edge of an auto-precharge burst closes the row
    a_r7_lock_end_closes: assert property (@(posedge clk) disable iff (!rstN)
      (lockCnt == LOCK_LAST && !actNow) |=> !isOpen);
    // R7: a lock never outlives its burst
    a_r7_lock_bounded: assert property (@(posedge clk) disable iff (!rstN)
      (lockCnt != '0) |=> (lockCnt < $past(lockCnt) || $past(preNow)));
  end

  logic [AGE_W-1:0] rrdAge, mrsAge;
  logic [DQM_W-1:0] dqmD1, dqmD2;
  logic [1:0]       warm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckePrev <= 1'b1;
      rrdAge  <= AGE_MAX;
      mrsAge  <= AGE_MAX;
      wrMask  <= '0;
      dqmD1   <= '0;
      dqmD2   <= '0;
      readHiZ <= '0;
      warm    <= '0;
    end else begin
      ckePrev <= cke;
      rrdAge  <= strb.act ? AGE_ONE : ((rrdAge == AGE_MAX) ? rrdAge : rrdAge + 1'b1);
      mrsAge  <= strb.mrs ? AGE_ONE : ((mrsAge == AGE_MAX) ? mrsAge : mrsAge + 1'b1);
      wrMask  <= dqm;
      dqmD1   <= dqm;
      dqmD2   <= dqmD1;
      readHiZ <= dqmD2;
      if (warm != 2'd3) warm <= warm + 1'b1;
    end
  end

  assign rrdShort = (rrdAge < LIM_RRD);
  assign mrsShort = (mrsAge < LIM_GAP);

  // R11: write masking has no lag
  a_r11_write_mask_now: assert property (@(posedge clk) disable iff (!rstN)
    (warm != 2'd0) |-> (wrMask == $past(dqm)));
  // R12: read masking lags the sample by two edges
  a_r12_read_hiz_lag: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3) |-> (readHiZ == $past(dqm, 3)));
endmodule

// File: rtl/sdram_mon_rules.sv
module sdram_mon_rules import sdram_mon_pkg::*; (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [1:0]           ba,
  input  logic                 apBit,
  input  logic                 ckePrev,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic [NUM_BANKS-1:0] bankLocked,
  input  logic [NUM_BANKS-1:0] rcdShort,
  input  logic [NUM_BANKS-1:0] rasShort,
  input  logic [NUM_BANKS-1:0] rcShort,
  input  logic [NUM_BANKS-1:0] rpShort,
  input  logic                 rrdShort,
  input  logic                 mrsShort,
  output strobe_t              strb,
  output logic                 errValid,
  output logic [CODE_W-1:0]    errCode,
  output logic [BANK_W-1:0]    errBank
);
  cmd_e                 cmd;
  err_e                 errNext;
  logic [BANK_W-1:0]    bank, bankNext, lowOpen, lowRas;
  logic [NUM_BANKS-1:0] rasFail;
  logic                 isCmd;

  always_comb begin
    unique casez ({csN, rasN, casN, weN})
      4'b1???: cmd = CMD_NONE;
      4'b0011: cmd = CMD_ACT;
      4'b0101: cmd = CMD_READ;
      4'b0100: cmd = CMD_WRITE;
      4'b0010: cmd = CMD_PRE;
      4'b0001: cmd = CMD_REF;
      4'b0000: cmd = CMD_MRS;
      4'b0110: cmd = CMD_OTHER;
      default: cmd = CMD_NONE;
    endcase
    isCmd = (cmd != CMD_NONE);
    bank  = {ba[0], ba[1]};
  end

  always_comb begin
    rasFail = bankOpen & rasShort;
    lowOpen = '0;
    lowRas  = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (bankOpen[b]) lowOpen = BANK_W'(b);
      if (rasFail[b])  lowRas  = BANK_W'(b);
    end
  end

  always_comb begin
    strb = '0;
    if (ckePrev) begin
      strb.bank    = bank;
      strb.act     = (cmd == CMD_ACT);
      strb.rdwr    = (cmd == CMD_READ) || (cmd == CMD_WRITE);
      strb.autoPre = apBit;
      strb.pre     = (cmd == CMD_PRE);
      strb.preAll  = apBit;
      strb.mrs     = (cmd == CMD_MRS);
    end
  end

  always_comb begin
    errNext  = ERR_NONE;
    bankNext = bank;
    if (isCmd && !ckePrev) begin
      errNext = ERR_FROZEN;
    end else if (isCmd && mrsShort) begin
      errNext = ERR_MRS_GAP;
    end else begin
      case (cmd)
        CMD_MRS: if (|bankOpen) begin errNext = ERR_MRS_BUSY; bankNext = lowOpen; end
        CMD_REF: if (|bankOpen) begin errNext = ERR_REF_BUSY; bankNext = lowOpen; end
        CMD_READ, CMD_WRITE: begin
          if (bankLocked[bank])     errNext = ERR_LOCKED;
          else if (!bankOpen[bank]) errNext = ERR_INACTIVE;
          else if (rcdShort[bank])  errNext = ERR_RCD;
        end
        CMD_ACT: begin
          if (bankOpen[bank])      errNext = ERR_DOUBLE_ACT;
          else if (rrdShort)       errNext = ERR_RRD;
          else if (rpShort[bank])  errNext = ERR_RP;
          else if (rcShort[bank])  errNext = ERR_RC;
        end
        CMD_PRE: begin
          if (apBit) begin
            if (|rasFail) begin errNext = ERR_RAS; bankNext = lowRas; end
          end else if (rasFail[bank]) begin
            errNext = ERR_RAS;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errValid <= 1'b0;
      errCode  <= '0;
      errBank  <= '0;
    end else begin
      errValid <= (errNext != ERR_NONE);
      errCode  <= errNext;
      errBank  <= bankNext;
    end
  end

  // R2: a command during a frozen clock is always reported as frozen
  a_r2_frozen_flag: assert property (@(posedge clk) disable iff (!rstN)
    (!ckePrev && isCmd) |=> (errValid && errCode == ERR_FROZEN));
  // R5: the mode-set gap always produces a report
  a_r5_gap_flag: assert property (@(posedge clk) disable iff (!rstN)
    (ckePrev && isCmd && mrsShort) |=> errValid);
  // R6: an access to a closed row is always reported
  a_r6_closed_access: assert property (@(posedge clk) disable iff (!rstN)
    (ckePrev && (cmd == CMD_READ || cmd == CMD_WRITE) && !bankOpen[bank]) |=> errValid);
  // R10: a report always carries a defined code
  a_r10_code_defined: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> (errCode != 4'd0 && errCode <= 4'd12));
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor import sdram_mon_pkg::*; #(
  parameter int T_RCD     = 2,
  parameter int T_RRD     = 2,
  parameter int T_RP      = 2,
  parameter int T_RAS     = 5,
  parameter int T_RC      = 7,
  parameter int MRS_GAP   = 2,
  parameter int BURST_LEN = 4,
  parameter int DQM_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              cke,
  input  logic [1:0]        ba,
  input  logic              apBit,
  input  logic [DQM_W-1:0]  dqm,
  output logic              errValid,
  output logic [3:0]        errCode,
  output logic [1:0]        errBank,
  output logic [DQM_W-1:0]  wrMask,
  output logic [DQM_W-1:0]  readHiZ
);
  strobe_t              strb;
  logic                 ckePrev, rrdShort, mrsShort;
  logic [NUM_BANKS-1:0] bankOpen, bankLocked, rcdShort, rasShort, rcShort, rpShort;

  sdram_mon_rules u_rules (
    .clk, .rstN, .csN, .rasN, .casN, .weN, .ba, .apBit, .ckePrev,
    .bankOpen, .bankLocked, .rcdShort, .rasShort, .rcShort, .rpShort,
    .rrdShort, .mrsShort, .strb, .errValid, .errCode, .errBank
  );

  sdram_mon_track #(
    .T_RCD(T_RCD), .T_RRD(T_RRD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC),
    .MRS_GAP(MRS_GAP), .BURST_LEN(BURST_LEN), .DQM_W(DQM_W)
  ) u_track (
    .clk, .rstN, .strb, .cke, .dqm, .ckePrev,
    .bankOpen, .bankLocked, .rcdShort, .rasShort, .rcShort, .rpShort,
    .rrdShort, .mrsShort, .wrMask, .readHiZ
  );
endmodule

// File: tb/sdram_cmd_monitor_bench.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_bench;
  localparam int DQM_W = 8;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                         C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000, C_DES = 4'b1000;
  // fields: requirement(4) command(4) ba(2) apBit(1) expValid(1) expCode(4) expBank(2)
  localparam int NV = 30;
  localparam logic [17:0] VEC [NV] = '{
    {4'd4,  C_MRS, 2'b00, 1'b0, 1'b0, 4'd0,  2'd0}, // R4 mode set, all idle
    {4'd5,  C_REF, 2'b00, 1'b0, 1'b1, 4'd2,  2'd0}, // R5 gap
    {4'd8,  C_ACT, 2'b10, 1'b0, 1'b0, 4'd0,  2'd0}, // R8 bank 1 opens
    {4'd8,  C_ACT, 2'b01, 1'b0, 1'b1, 4'd9,  2'd2}, // R8 tRRD, R3 bank 2
    {4'd8,  C_RD,  2'b10, 1'b0, 1'b0, 4'd0,  2'd0}, // R8 tRCD met
    {4'd6,  C_RD,  2'b00, 1'b0, 1'b1, 4'd6,  2'd0}, // R6 closed bank
    {4'd6,  C_ACT, 2'b10, 1'b0, 1'b1, 4'd8,  2'd1}, // R6 double activate
    {4'd9,  C_PRE, 2'b10, 1'b0, 1'b1, 4'd12, 2'd1}, // R9 tRAS
    {4'd9,  C_ACT, 2'b10, 1'b0, 1'b1, 4'd10, 2'd1}, // R9 tRP
    {4'd4,  C_MRS, 2'b00, 1'b0, 1'b1, 4'd3,  2'd1}, // R4 mode set busy
    {4'd1,  C_NOP, 2'b00, 1'b0, 1'b0, 4'd0,  2'd0}, // R1 no-op after gap
    {4'd1,  C_DES, 2'b11, 1'b0, 1'b0, 4'd0,  2'd0}, // R1 deselect hides pins
    {4'd13, C_PRE, 2'b00, 1'b1, 1'b1, 4'd12, 2'd1}, // R13 precharge all
    {4'd4,  C_REF, 2'b00, 1'b0, 1'b0, 4'd0,  2'd0}, // R4 refresh idle
    {4'd3,  C_ACT, 2'b11, 1'b0, 1'b0, 4'd0,  2'd0}, // R3 bank 3
    {4'd1,  C_NOP, 2'b00, 1'b0, 1'b0, 4'd0,  2'd0}, // R1
    {4'd7,  C_WR,  2'b11, 1'b1, 1'b0, 4'd0,  2'd0}, // R7 auto-precharge write
    {4'd7,  C_RD,  2'b11, 1'b0, 1'b1, 4'd5,  2'd3}, // R7 locked
    {4'd7,  C_WR,  2'b11, 1'b0, 1'b1, 4'd5,  2'd3}, // R7 locked
    {4'd7,  C_NOP, 2'b00, 1'b0, 1'b0, 4'd0,  2'd0}, // R7 last data edge
    {4'd7,  C_ACT, 2'b11, 1'b0, 1'b1, 4'd10, 2'd3}, // R7 tRP after burst
    {4'd1,  C_NOP, 2'b00, 1'b0, 1'b0, 4'd0,  2'd0}, // R1
    {4'd9,  C_PRE, 2'b11, 1'b0, 1'b1, 4'd12, 2'd3}, // R9 tRAS
    {4'd1,  C_NOP, 2'b00, 1'b0, 1'b0, 4'd0,  2'd0}, // R1
    {4'd1,  C_NOP, 2'b00, 1'b0, 1'b0, 4'd0,  2'd0}, // R1
    {4'd9,  C_ACT, 2'b11, 1'b0, 1'b1, 4'd11, 2'd3}, // R9 tRC
    {4'd8,  C_ACT, 2'b01, 1'b0, 1'b1, 4'd9,  2'd2}, // R8 tRRD
    {4'd8,  C_RD,  2'b01, 1'b0, 1'b1, 4'd7,  2'd2}, // R8 tRCD
    {4'd8,  C_RD,  2'b01, 1'b0, 1'b0, 4'd0,  2'd0}, // R8 tRCD met
    {4'd10, C_NOP, 2'b00, 1'b0, 1'b0, 4'd0,  2'd0}  // R10 pulse ends
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic csN, rasN, casN, weN, cke, apBit;
  logic [1:0] ba;
  logic [DQM_W-1:0] dqm;
  logic errValid;
  logic [3:0] errCode;
  logic [1:0] errBank;
  logic [DQM_W-1:0] wrMask, readHiZ;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdram_cmd_monitor u_sdram_cmd_monitor (
    .clk, .rstN, .csN, .rasN, .casN, .weN, .cke, .ba, .apBit, .dqm,
    .errValid, .errCode, .errBank, .wrMask, .readHiZ
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [1:0] b, input logic ap,
                       input logic k, input logic [DQM_W-1:0] m);
    {csN, rasN, casN, weN} = c;
    ba = b; apBit = ap; cke = k; dqm = m;
  endtask

  // Inputs are set at a falling edge, sampled at the next rising edge, checked 2 ns later.
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic nextDrive();
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    drive(C_NOP, 2'b00, 1'b0, 1'b1, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic expectErr(input logic v, input logic [3:0] code, input logic [1:0] bk,
                           input string tag);
    logic [6:0] act, exp;
    act = v ? {errValid, errCode, errBank} : {errValid, 6'd0};
    exp = {v, v ? code : 4'd0, v ? bk : 2'd0};
    chk(act == exp, tag, act, exp);
  endtask

  initial begin
    logic [DQM_W-1:0] hist1, hist2;
    logic [DQM_W-1:0] pat [6];
    drive(C_NOP, 2'b00, 1'b0, 1'b1, '0);
    doReset();
    // R10 reset state
    @(negedge clk);
    rstN = 1'b0;
    step();
    chk({errValid, wrMask, readHiZ} == '0, "R10 reset outputs", {errValid, wrMask, readHiZ}, 0);
    doReset();

    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      drive(v[13:10], v[9:8], v[7], 1'b1, '0);
      step();
      expectErr(v[6], v[5:2], v[1:0], $sformatf("R%0d table row %0d", v[17:14], i));
      nextDrive();
    end

    // R2: frozen clock reports code 1 and leaves the bank closed
    doReset();
    drive(C_NOP, 2'b00, 1'b0, 1'b0, '0); step(); expectErr(1'b0, 4'd0, 2'd0, "R2 cke low no-op"); nextDrive();
    drive(C_ACT, 2'b00, 1'b0, 1'b1, '0); step(); expectErr(1'b1, 4'd1, 2'd0, "R2 frozen activate"); nextDrive();
    drive(C_RD,  2'b00, 1'b0, 1'b1, '0); step(); expectErr(1'b1, 4'd6, 2'd0, "R2 frozen left bank closed"); nextDrive();

    // R10 priority: frozen beats the mode-set gap
    doReset();
    drive(C_MRS, 2'b00, 1'b0, 1'b0, '0); step(); expectErr(1'b0, 4'd0, 2'd0, "R10 mode set with cke falling"); nextDrive();
    drive(C_REF, 2'b00, 1'b0, 1'b1, '0); step(); expectErr(1'b1, 4'd1, 2'd0, "R10 frozen over gap"); nextDrive();
    drive(C_NOP, 2'b00, 1'b0, 1'b1, '0); step(); expectErr(1'b0, 4'd0, 2'd0, "R10 single pulse"); nextDrive();

    // R11, R12: mask views, with an error report in the same cycle
    doReset();
    pat = '{8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h81, 8'h00};
    hist1 = '0; hist2 = '0;
    for (int i = 0; i < 6; i++) begin
      drive((i == 3) ? C_RD : C_NOP, 2'b00, 1'b0, 1'b1, pat[i]);
      step();
      chk(wrMask == pat[i], "R11 write mask", wrMask, pat[i]);
      chk(readHiZ == hist2, "R12 read high-z", readHiZ, hist2);
      if (i == 3) expectErr(1'b1, 4'd6, 2'd0, "R6 error alongside mask");
      hist2 = hist1; hist1 = pat[i];
      nextDrive();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end
endmodule